// File: doc/BRIEF.md
# SDRAM Burst Write Command Sequencer

This block turns one multi-beat write request into the command train that an SDRAM needs when it always runs with a burst length of one. A request carries a bank, a row, a byte column, a transfer size and a stream of data words. The block first opens the row. It then issues one single-beat write for each bus-wide word of the transfer. Only the last of these writes has the auto-precharge address bit set.

After the final write the sequencer holds the bank for two waits, each set by a two-bit field. The first covers write recovery before the precharge starts. The second covers the time the device needs to finish that precharge. A one-hot busy vector marks only the bank that is being written, so a neighbouring arbiter can still send traffic to the other banks.

Each write beat takes its data word in the same cycle that the write command appears on the pins. Transfers no wider than the data bus use a single write and enable only the byte lanes they cover.

Top module: `sdram_burst_wr_seq`

## Requirements
- R1: When `req_valid` is high while `req_ready` is high, the next cycle drives ACTIVE (`cs_n,ras_n,cas_n,we_n` = 0,0,1,1), with the request bank on `sd_ba` and the row on `sd_addr`.
- R2: The ACTIVE cycle is followed at once by a run of WRITE commands (0,1,0,0). The run has size/B beats when the size in bytes is larger than B, and one beat otherwise. B is the bus width in bytes (4 by default), and `req_size` codes 0..4 stand for 1, 2, 4, 8 and 16 bytes.
- R3: Address bit 10 is high on the final write of a run only, which selects auto-precharge. Every earlier write has it low.
- R4: The first write carries the request column with its low log2(B) bits cleared, on `sd_addr[COL_W-1:0]`. Each later write adds B to the column, modulo 2^COL_W.
- R5: `data_take` is high exactly in the write cycles, and `sd_dq` equals `wr_data` in each of those cycles.
- R6: `sd_dqm` bit i masks byte lane i (`sd_dq[8i+7:8i]`), and 1 means masked. For sizes of B bytes or more, every lane is enabled. For smaller sizes, only lanes col%B through col%B+size-1 are enabled.
- R7: After the final write, NOP (0,1,1,1) is held for the recovery field value plus one cycles (1 to 4).
- R8: Then NOP is held for the precharge field value plus one cycles. After that the outputs return to deselect (all four pins high).
- R9: `req_ready` is low from the cycle after acceptance until the last precharge-wait cycle. Requests offered during that time are not taken.
- R10: `bank_busy` has exactly the bit of the accessed bank set, from the ACTIVE cycle through the last precharge-wait cycle, and is zero while idle.
- R11: Both wait fields, and all request fields, are captured at acceptance. Changes to them during a sequence have no effect on that sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request offered |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Row to open |
| req_col | input | COL_W | Byte column of the first byte |
| req_size | input | 3 | log2 of transfer size in bytes |
| cfg_trwl | input | 2 | Write-recovery wait field (cycles minus one) |
| cfg_trp | input | 2 | Precharge-completion wait field (cycles minus one) |
| wr_data | input | DATA_W | Data word for the current beat |
| data_take | output | 1 | Current `wr_data` is consumed this cycle |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank address |
| sd_addr | output | ADDR_W | Row / column address, bit 10 auto-precharge |
| sd_dq | output | DATA_W | Write data |
| sd_dqm | output | DATA_W/8 | Byte masks, 1 masks a lane |
| bank_busy | output | BANKS | One-hot busy flag of the accessed bank |

## Verification
The assertions rely on the following input assumptions:
- `req_size` never exceeds 16 bytes.
- For transfers of a bus word or more, the column is aligned to the transfer size.
- For sub-word transfers, the column offset is a multiple of the size, so the enabled lanes never run past the word.
- `wr_data` is valid in every cycle that `data_take` is high.

The stimulus respects all of these. Every request uses sizes 0..4 with aligned columns. Data comes straight from a beat counter that advances on `data_take`. One request keeps `req_valid` high with altered fields and wait settings while the sequence runs. This exercises the ignore and capture rules without breaking the assumptions.

// File: rtl/sbw_pkg.sv
package sbw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACT,
    ST_WR,
    ST_REC,
    ST_PRE
  } sbw_state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sbw_pins_t;

  localparam sbw_pins_t PINS_DESEL = 4'b1111;
  localparam sbw_pins_t PINS_NOP   = 4'b0111;
  localparam sbw_pins_t PINS_ACT   = 4'b0011;
  localparam sbw_pins_t PINS_WRITE = 4'b0100;

  // number of single-beat writes for a transfer of 2**sz bytes
  function automatic int unsigned beats_of(input logic [2:0] sz,
                                           input int unsigned bus_log2);
    int unsigned s;
    s = {29'd0, sz};
    if (s <= bus_log2) return 32'd1;
    return 32'd1 << (s - bus_log2);
  endfunction

  // is byte lane 'lane' written by a transfer of 2**sz bytes at offset 'off'
  function automatic logic lane_enabled(input logic [2:0] sz,
                                        input int unsigned off,
                                        input int unsigned lane,
                                        input int unsigned bus_log2);
    int unsigned s;
    s = {29'd0, sz};
    if (s >= bus_log2) return 1'b1;
    return (lane >= off) && (lane < off + (32'd1 << s));
  endfunction

endpackage

// File: rtl/sbw_lane_plan.sv
module sbw_lane_plan #(
  parameter int unsigned BB      = 4,
  parameter int unsigned BB_LOG2 = 2,
  parameter int unsigned BEAT_W  = 3
) (
  input  logic [2:0]         size,
  input  logic [BB_LOG2-1:0] offset,
  output logic [BB-1:0]      dqm,
  output logic [BEAT_W-1:0]  beats
);

  assign beats = BEAT_W'(sbw_pkg::beats_of(size, BB_LOG2));

  for (genvar g = 0; g < BB; g++) begin : g_lane
    assign dqm[g] = !sbw_pkg::lane_enabled(size, 32'(offset), g, BB_LOG2);
  end

endmodule

// File: rtl/sbw_wait_timer.sv
module sbw_wait_timer #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             active,
  output logic             last
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (load) begin
      active <= 1'b1;
      cnt    <= load_val;
    end else if (active) begin
      if (cnt == '0) active <= 1'b0;
      else           cnt    <= cnt - 1'b1;
    end
  end

  assign last = active && (cnt == '0);

  // a wait is only started once the previous one has ended
  assert_load_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !active);

endmodule

// File: rtl/sbw_bank_flags.sv
module sbw_bank_flags #(
  parameter int unsigned BANKS  = 4,
  parameter int unsigned BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic [BANK_W-1:0] bank,
  output logic [BANKS-1:0]  busy
);

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    assign busy[b] = hold && (bank == BANK_W'(b));
  end

  // only the accessed bank is ever blocked
  assert_busy_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(busy));

endmodule

// File: rtl/sdram_burst_wr_seq.sv
module sdram_burst_wr_seq #(
  parameter int unsigned DATA_W        = 32,
  parameter int unsigned BANKS         = 4,
  parameter int unsigned ROW_W         = 13,
  parameter int unsigned COL_W         = 10,
  parameter int unsigned ADDR_W        = 13,
  parameter int unsigned SIZE_LOG2_MAX = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [$clog2(BANKS)-1:0]   req_bank,
  input  logic [ROW_W-1:0]           req_row,
  input  logic [COL_W-1:0]           req_col,
  input  logic [2:0]                 req_size,
  input  logic [1:0]                 cfg_trwl,
  input  logic [1:0]                 cfg_trp,
  input  logic [DATA_W-1:0]          wr_data,
  output logic                       data_take,
  output logic                       sd_cs_n,
  output logic                       sd_ras_n,
  output logic                       sd_cas_n,
  output logic                       sd_we_n,
  output logic [$clog2(BANKS)-1:0]   sd_ba,
  output logic [ADDR_W-1:0]          sd_addr,
  output logic [DATA_W-1:0]          sd_dq,
  output logic [DATA_W/8-1:0]        sd_dqm,
  output logic [BANKS-1:0]           bank_busy
);
  import sbw_pkg::*;

  localparam int unsigned BB        = DATA_W / 8;
  localparam int unsigned BB_LOG2   = $clog2(BB);
  localparam int unsigned BANK_W    = $clog2(BANKS);
  localparam int unsigned MAX_BEATS = (SIZE_LOG2_MAX > BB_LOG2) ? (1 << (SIZE_LOG2_MAX - BB_LOG2)) : 1;
  localparam int unsigned BEAT_W    = $clog2(MAX_BEATS + 1);
  localparam int unsigned AP_BIT    = 10;

  sbw_state_e          state;
  logic [BANK_W-1:0]   bank_q;
  logic [ROW_W-1:0]    row_q;
  logic [COL_W-1:0]    col_q;
  logic [BEAT_W-1:0]   beats_q, beat_q;
  logic [BB-1:0]       dqm_q;
  logic [1:0]          trwl_q, trp_q;

  logic [BB-1:0]       dqm_n;
  logic [BEAT_W-1:0]   beats_n;

  // named events
  logic accept, act_fire, wr_fire, last_beat, rec_last, pre_last, rec_active, pre_active;
  sbw_pins_t pins;

  assign accept    = (state == ST_IDLE) && req_valid;
  assign act_fire  = (state == ST_ACT);
  assign wr_fire   = (state == ST_WR);
  assign last_beat = wr_fire && (beat_q == beats_q - 1'b1);

  sbw_lane_plan #(.BB(BB), .BB_LOG2(BB_LOG2), .BEAT_W(BEAT_W)) u_plan (
    .size   (req_size),
    .offset (req_col[BB_LOG2-1:0]),
    .dqm    (dqm_n),
    .beats  (beats_n)
  );

  sbw_wait_timer #(.CNT_W(2)) u_rec (
    .clk(clk), .rst_n(rst_n), .load(last_beat), .load_val(trwl_q),
    .active(rec_active), .last(rec_last)
  );

  sbw_wait_timer #(.CNT_W(2)) u_pre (
    .clk(clk), .rst_n(rst_n), .load(rec_last), .load_val(trp_q),
    .active(pre_active), .last(pre_last)
  );

  sbw_bank_flags #(.BANKS(BANKS), .BANK_W(BANK_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .hold(state != ST_IDLE), .bank(bank_q), .busy(bank_busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bank_q  <= '0;
      row_q   <= '0;
      col_q   <= '0;
      beats_q <= '0;
      beat_q  <= '0;
      dqm_q   <= '1;
      trwl_q  <= '0;
      trp_q   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          bank_q  <= req_bank;
          row_q   <= req_row;
          col_q   <= {req_col[COL_W-1:BB_LOG2], {BB_LOG2{1'b0}}};
          beats_q <= beats_n;
          dqm_q   <= dqm_n;
          trwl_q  <= cfg_trwl;
          trp_q   <= cfg_trp;
          beat_q  <= '0;
          state   <= ST_ACT;
        end
        ST_ACT: state <= ST_WR;
        ST_WR: begin
          col_q  <= col_q + COL_W'(BB);
          beat_q <= beat_q + 1'b1;
          if (last_beat) state <= ST_REC;
        end
        ST_REC: if (rec_last) state <= ST_PRE;
        ST_PRE: if (pre_last) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    pins    = PINS_DESEL;
    sd_addr = '0;
    case (state)
      ST_ACT: begin
        pins    = PINS_ACT;
        sd_addr = ADDR_W'(row_q);
      end
      ST_WR: begin
        pins                 = PINS_WRITE;
        sd_addr[COL_W-1:0]   = col_q;
        sd_addr[AP_BIT]      = last_beat;
      end
      ST_REC, ST_PRE: pins = PINS_NOP;
      default: pins = PINS_DESEL;
    endcase
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = pins;
  assign sd_ba     = (state != ST_IDLE) ? bank_q : '0;
  assign sd_dq     = wr_fire ? wr_data : '0;
  assign sd_dqm    = wr_fire ? dqm_q : '1;
  assign data_take = wr_fire;
  assign req_ready = (state == ST_IDLE);

  // ---------------- assertions ----------------
  assert_act_follows_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!sd_cs_n && !sd_ras_n && sd_cas_n && sd_we_n &&
      sd_ba == $past(req_bank) && sd_addr == ADDR_W'($past(req_row))));

  assert_write_after_act_R2: assert property (@(posedge clk) disable iff (!rst_n)
    act_fire |=> data_take);

  assert_ap_closes_burst_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_take && sd_addr[AP_BIT]) |=> !data_take);

  assert_plain_write_continues_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_take && !sd_addr[AP_BIT]) |=> data_take);

  assert_col_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_take && $past(data_take)) |->
      sd_addr[COL_W-1:0] == $past(sd_addr[COL_W-1:0]) + COL_W'(BB));

  assert_mask_has_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
    data_take |-> !(&sd_dqm));

  assert_prech_after_recovery_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pre_active) |-> $past(rec_active));

  assert_idle_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (bank_busy == '0));

  assert_busy_while_active_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> ($countones(bank_busy) == 1));

endmodule

// File: tb/tb_sdram_burst_wr_seq.sv
`timescale 1ns/1ps
module tb_sdram_burst_wr_seq;

  typedef struct {
    int          kind;   // 0 activate, 1 write, 2 nop
    logic [1:0]  ba;
    logic [12:0] a;
    logic [31:0] dq;
    logic [3:0]  dqm;
    string       tag;
  } exp_t;

  exp_t q[$];
  exp_t mon_e;
  int n_vec = 0;
  int n_bad = 0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_bank = '0;
  logic [12:0] req_row = '0;
  logic [9:0]  req_col = '0;
  logic [2:0]  req_size = '0;
  logic [1:0]  cfg_trwl = '0;
  logic [1:0]  cfg_trp = '0;
  logic [31:0] wr_data;
  logic        data_take;
  logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0]  sd_ba;
  logic [12:0] sd_addr;
  logic [31:0] sd_dq;
  logic [3:0]  sd_dqm;
  logic [3:0]  bank_busy;

  logic [31:0] data_base = 32'h0;
  logic [31:0] beat_idx = 32'h0;
  assign wr_data = data_base + beat_idx * 32'h01010101;
  always @(posedge clk) begin
    if (req_valid && req_ready) beat_idx <= 32'h0;
    else if (data_take)         beat_idx <= beat_idx + 32'h1;
  end

  sdram_burst_wr_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_size(req_size),
    .cfg_trwl(cfg_trwl), .cfg_trp(cfg_trp), .wr_data(wr_data), .data_take(data_take),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dq(sd_dq), .sd_dqm(sd_dqm), .bank_busy(bank_busy)
  );

  task automatic check(input string tag, input string what,
                       input longint unsigned act, input longint unsigned expv);
    n_vec++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  // monitor: pops one expected item per selected-chip cycle
  always @(negedge clk) begin
    if (rst_n && !sd_cs_n) begin
      if (q.size() == 0) begin
        check("R2", "unexpected command", 1, 0);
      end else begin
        mon_e = q.pop_front();
        check(mon_e.tag, "command pins", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n},
              (mon_e.kind == 0) ? 4'b0011 : (mon_e.kind == 1) ? 4'b0100 : 4'b0111);
        check("R10", "bank_busy", bank_busy, 4'b0001 << mon_e.ba);
        check("R9", "req_ready while active", req_ready, 0);
        if (mon_e.kind == 0) begin
          check("R1", "bank", sd_ba, mon_e.ba);
          check("R1", "row", sd_addr, mon_e.a);
          check("R5", "data_take off", data_take, 0);
        end else if (mon_e.kind == 1) begin
          check("R2", "bank", sd_ba, mon_e.ba);
          check("R4", "column", sd_addr[9:0], mon_e.a[9:0]);
          check("R3", "auto-precharge bit", sd_addr[10], mon_e.a[10]);
          check("R5", "data", sd_dq, mon_e.dq);
          check("R5", "data_take", data_take, 1);
          check("R6", "byte mask", sd_dqm, mon_e.dqm);
        end else begin
          check("R5", "data_take off", data_take, 0);
        end
      end
    end
  end

  // driver: push the expected train, then offer the request
  task automatic send(input logic [1:0] ba, input logic [12:0] row, input logic [9:0] col,
                      input logic [2:0] sz, input logic [1:0] trwl, input logic [1:0] trp,
                      input bit hold_valid, input string rtag, input string ptag);
    int nb;
    int off;
    int guard;
    logic [9:0] cw;
    logic [3:0] m;
    exp_t e;
    nb  = (sz <= 3'd2) ? 1 : (1 << (sz - 3'd2));
    cw  = col & 10'h3FC;
    off = int'(col[1:0]);
    for (int l = 0; l < 4; l++)
      m[l] = !((sz >= 3'd2) || (l >= off && l < off + (1 << sz)));
    data_base = {ba, row, 17'h0} ^ 32'hA5C30000;

    e.ba = ba; e.dq = '0; e.dqm = '1;
    e.kind = 0; e.a = row; e.tag = "R1"; q.push_back(e);
    for (int i = 0; i < nb; i++) begin
      logic [9:0] c;
      c = cw + 10'(4 * i);
      e.kind = 1;
      e.a = {2'b00, (i == nb - 1), c};
      e.dq = data_base + 32'(i) * 32'h01010101;
      e.dqm = m;
      e.tag = "R2";
      q.push_back(e);
    end
    e.dq = '0; e.dqm = '1; e.a = '0; e.kind = 2;
    for (int i = 0; i <= int'(trwl); i++) begin e.tag = rtag; q.push_back(e); end
    for (int i = 0; i <= int'(trp); i++)  begin e.tag = ptag; q.push_back(e); end

    req_bank = ba; req_row = row; req_col = col; req_size = sz;
    cfg_trwl = trwl; cfg_trp = trp; req_valid = 1'b1;
    @(negedge clk);                    // taken at the edge in between
    if (hold_valid) begin
      // R9 / R11: keep offering a different request and settings while busy
      req_bank = ~ba; req_row = ~row; req_col = col ^ 10'h100;
      cfg_trwl = ~trwl; cfg_trp = ~trp;
      repeat (3) @(negedge clk);
    end
    req_valid = 1'b0;

    guard = 0;
    while (q.size() != 0 && guard < 200) begin @(negedge clk); guard++; end
    if (guard >= 200) check("R2", "sequence completed", 0, 1);
    @(negedge clk);
    check("R8", "deselect after precharge wait", sd_cs_n, 1);
    check("R9", "req_ready back high", req_ready, 1);
    check("R10", "bank_busy cleared", bank_busy, 0);
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", "reset req_ready", req_ready, 1);
        check("R10", "reset bank_busy", bank_busy, 0);
        check("R8", "reset deselect", sd_cs_n, 1);
        check("R5", "reset data_take", data_take, 0);
        // 16 bytes: four writes, shortest waits
        send(2'd0, 13'h0123, 10'h040, 3'd4, 2'd0, 2'd0, 1'b0, "R7", "R8");
        // 8 bytes: two writes, long recovery
        send(2'd1, 13'h1ABC, 10'h108, 3'd3, 2'd3, 2'd2, 1'b0, "R7", "R8");
        // one word, all lanes
        send(2'd3, 13'h0FFF, 10'h3FC, 3'd2, 2'd1, 2'd3, 1'b0, "R7", "R8");
        // half word in upper lanes (R6)
        send(2'd2, 13'h0555, 10'h012, 3'd1, 2'd2, 2'd1, 1'b0, "R7", "R8");
        // single byte in top lane (R6)
        send(2'd1, 13'h0AAA, 10'h07B, 3'd0, 2'd0, 2'd2, 1'b0, "R7", "R8");
        // single byte in lane 0 (R6)
        send(2'd0, 13'h0001, 10'h200, 3'd0, 2'd1, 2'd0, 1'b0, "R7", "R8");
        // 16 bytes near column top, request held and settings changed (R9, R11)
        send(2'd2, 13'h1F00, 10'h3F0, 3'd4, 2'd1, 2'd2, 1'b1, "R11", "R11");
        // 16 bytes at the longest waits
        send(2'd3, 13'h0777, 10'h080, 3'd4, 2'd3, 2'd3, 1'b0, "R7", "R8");
      end
      begin
        repeat (100000) @(posedge clk);
        check("R9", "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule